// File: doc/BRIEF.md
# Flash operation status reporter

This block models the read path of a parallel NOR flash while an internal program or erase job is running. A write pulse is a rising edge of the write strobe while the chip is selected. The block counts these pulses to recognise a four-write program sequence or a six-write erase sequence. Once the final pulse of a sequence has been accepted, an internal cycle-count timer runs the job. Until the job ends, host reads return a synthesized status byte in place of array data.

The status byte has three meaningful bits: a polling bit, a toggle bit and a failure flag. All other bits read 0. A small register file of sectors stands in for the flash array. Per-sector protect inputs make program and erase jobs skip data changes. An external strobe reports that the internal pulse count went over its limit. Every duration is a parameter counted in clock cycles. The protected-sector intervals are derived from the clock frequency: 2 µs for a program and 100 µs for an erase.

Top module: `flash_op_status`

## Requirements
- R1: After reset every array byte reads 0xFF. A read is active while both chip-enable and output-enable are low. With no job running, an active read returns the byte at the address, and `rdata` is 0x00 whenever no read is active.
- R2: A program job starts on the 4th write pulse, provided the 3rd pulse carried 0xA0. The 4th pulse supplies the target address and byte. While the job runs, reads return bit 7 as the complement of that byte's bit 7, bit 5 = 0 and bits 4..0 = 0. After PROG_CYC cycles the byte is stored and later reads return it.
- R3: An erase sequence has 0x80 on the 3rd pulse. On the 6th pulse, 0x10 selects every sector and 0x30 selects the sector given by the upper address bits (addr[3:2] by default). While the job runs, reads return bit 7 = 0. When it ends, the selected unprotected sectors read 0xFF and other sectors keep their data.
- R4: Before the final pulse of a sequence (4th for program, 6th for erase), reads return array data and not status.
- R5: While a job runs, bit 6 reads 0 on the first read after the job starts. It inverts at the end of every read, and a rise of either chip-enable or output-enable counts as a read ending. Once the job ends, reads return steady array data.
- R6: A program aimed at a protected sector reports status for 2·CLK_MHZ cycles and then returns to read mode with the byte unchanged.
- R7: An erase leaves protected sectors untouched. If every selected sector is protected, status is reported for 100·CLK_MHZ cycles and no byte changes.
- R8: A pulse-limit strobe during a job sets bit 5 = 1. The status then stays active, with bit 7 still driven by the polling rule, until a write pulse carrying 0xF0. No array byte changes from the failed job.
- R9: After a sector-erase command, a window of WIN_CYC cycles runs before the erase, and status is reported during it. Each further write of 0x30 within the window adds that address's sector and restarts the window.
- R10: If the 3rd pulse is neither 0xA0 nor 0x80, or the 6th pulse of an erase sequence is neither 0x10 nor 0x30, the sequence is dropped. No status becomes active, and the next pulse counts as the 1st of a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, a pulse is taken on its rising edge |
| addr | input | ADDR_W | Byte address, upper bits select the sector |
| wdata | input | 8 | Write data |
| sect_prot | input | SECT_N | Per-sector protect flags |
| pulse_limit | input | 1 | Strobe: internal pulse count exceeded |
| rdata | output | 8 | Read data or status byte |

## Verification
The bench reads part-way through both sequences, so a design that shows status too early returns a status byte where array data is expected. It alternates reads that end on output-enable with reads that end on chip-enable, which catches a toggle bit tied to only one strobe. It adds a second sector late in the erase window and samples between the unrestarted and restarted end times, so a window that does not restart ends too soon. It also runs protected-sector jobs and a failure strobe, where a design that writes anyway, ends early or drops the failure flag returns a wrong byte.

// File: rtl/flash_op_status_pkg.sv
package flash_op_status_pkg;

   localparam int FOS_DW = 8;

   typedef enum logic [2:0] {
      ST_READ,
      ST_PROG,
      ST_PPROT,
      ST_EWIN,
      ST_ERASE,
      ST_EPROT,
      ST_FAIL
   } op_state_t;

   // Status byte: polling bit, toggle bit, failure flag, rest zero.
   function automatic logic [FOS_DW-1:0] status_byte(input logic erase_job,
                                                     input logic target_d7,
                                                     input logic tog,
                                                     input logic failed);
      status_byte = {(erase_job ? 1'b0 : ~target_d7), tog, failed, 5'b00000};
   endfunction

endpackage

// File: rtl/fos_cmd_seq.sv
module fos_cmd_seq #(
   parameter logic [7:0] PROG_CMD  = 8'hA0,
   parameter logic [7:0] ERASE_CMD = 8'h80,
   parameter logic [7:0] CHIP_CMD  = 8'h10,
   parameter logic [7:0] SECT_CMD  = 8'h30
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce_n,
   input  logic       we_n,
   input  logic [7:0] wdata,
   input  logic       armed,
   output logic       wr_pulse,
   output logic       go_prog,
   output logic       go_chip,
   output logic       go_sect
);

   logic       we_q;
   logic [2:0] step;
   logic       erase_seq;
   logic       hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_q <= 1'b1;
      else        we_q <= we_n;
   end

   assign wr_pulse = !ce_n && !we_q && we_n;
   assign hit      = armed && wr_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step      <= 3'd0;
         erase_seq <= 1'b0;
      end else if (!armed) begin
         step      <= 3'd0;
         erase_seq <= 1'b0;
      end else if (wr_pulse) begin
         case (step)
            3'd2: begin
               if (wdata == PROG_CMD) begin
                  step      <= 3'd3;
                  erase_seq <= 1'b0;
               end else if (wdata == ERASE_CMD) begin
                  step      <= 3'd3;
                  erase_seq <= 1'b1;
               end else begin
                  step      <= 3'd0;
               end
            end
            3'd3:    step <= erase_seq ? 3'd4 : 3'd0;
            3'd5:    step <= 3'd0;
            default: step <= step + 3'd1;
         endcase
      end
   end

   assign go_prog = hit && (step == 3'd3) && !erase_seq;
   assign go_chip = hit && (step == 3'd5) && (wdata == CHIP_CMD);
   assign go_sect = hit && (step == 3'd5) && (wdata == SECT_CMD);

   a_r10_one_start: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({go_prog, go_chip, go_sect}));

   a_r10_bad_code_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && step == 3'd2 && wdata != PROG_CMD && wdata != ERASE_CMD) |=> (step == 3'd0));

   a_r4_no_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (step == 3'd0) |-> !(go_prog || go_chip || go_sect));

endmodule

// File: rtl/fos_busy_timer.sv
module fos_busy_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == CW'(1));

   a_r6_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/fos_sector.sv
module fos_sector #(
   parameter int WORDS = 4,
   parameter int OFS_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [OFS_W-1:0] wr_ofs,
   input  logic [7:0]       wr_data,
   input  logic             erase_en,
   input  logic [OFS_W-1:0] rd_ofs,
   output logic [7:0]       rd_data
);

   logic [WORDS-1:0][7:0] words;

   initial begin
      assert (WORDS == (1 << OFS_W)) else $error("WORDS must equal 2**OFS_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        words <= '1;
      else if (erase_en) words <= '1;
      else if (wr_en)    words[wr_ofs] <= wr_data;
   end

   assign rd_data = words[rd_ofs];

   a_r3_erased_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      erase_en |=> (words == '1));

endmodule

// File: rtl/fos_read_status.sv
module fos_read_status
   import flash_op_status_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              busy,
   input  logic              op_start,
   input  logic              erase_job,
   input  logic              target_d7,
   input  logic              failed,
   input  logic [FOS_DW-1:0] array_byte,
   output logic [FOS_DW-1:0] rdata
);

   logic read_act;
   logic act_q;
   logic read_end;
   logic tog;

   assign read_act = !ce_n && !oe_n;
   assign read_end = act_q && !read_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         tog   <= 1'b0;
      end else begin
         act_q <= read_act;
         if (op_start)              tog <= 1'b0;
         else if (busy && read_end) tog <= ~tog;
      end
   end

   always_comb begin
      if (!read_act)  rdata = '0;
      else if (busy)  rdata = status_byte(erase_job, target_d7, tog, failed);
      else            rdata = array_byte;
   end

   a_r5_flip_per_read: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && read_end && !op_start) |=> (tog != $past(tog)));

   a_r5_steady_within_read: assert property (@(posedge clk) disable iff (!rst_n)
      (read_act && busy && !read_end) |=> (!read_act || !busy || rdata[6] == $past(rdata[6])));

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
   import flash_op_status_pkg::*;
#(
   parameter int SECT_N     = 4,
   parameter int SECT_WORDS = 4,
   parameter int ADDR_W     = 4,
   parameter int CLK_MHZ    = 100,
   parameter int PROG_CYC   = 40,
   parameter int ERASE_CYC  = 300,
   parameter int WIN_CYC    = 50,
   parameter logic [7:0] PROG_CMD  = 8'hA0,
   parameter logic [7:0] ERASE_CMD = 8'h80,
   parameter logic [7:0] CHIP_CMD  = 8'h10,
   parameter logic [7:0] SECT_CMD  = 8'h30,
   parameter logic [7:0] RST_CMD   = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic [SECT_N-1:0] sect_prot,
   input  logic              pulse_limit,
   output logic [7:0]        rdata
);

   localparam int SW        = $clog2(SECT_N);
   localparam int OW        = $clog2(SECT_WORDS);
   localparam int PPROT_CYC = 2 * CLK_MHZ;
   localparam int EPROT_CYC = 100 * CLK_MHZ;
   localparam int MAX_A     = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int MAX_B     = (WIN_CYC > PPROT_CYC) ? WIN_CYC : PPROT_CYC;
   localparam int MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_CYC   = (MAX_C > EPROT_CYC) ? MAX_C : EPROT_CYC;
   localparam int CW        = $clog2(MAX_CYC + 1);

   initial begin
      assert (SECT_N >= 2 && (SECT_N & (SECT_N - 1)) == 0)
         else $error("SECT_N must be a power of two, at least 2");
      assert (SECT_WORDS >= 2 && (SECT_WORDS & (SECT_WORDS - 1)) == 0)
         else $error("SECT_WORDS must be a power of two, at least 2");
      assert (ADDR_W == SW + OW) else $error("ADDR_W must cover sectors and words");
      assert (PROG_CYC >= 2 && ERASE_CYC >= 2 && WIN_CYC >= 2 && CLK_MHZ >= 1)
         else $error("durations must be at least two cycles");
      assert (PROG_CMD != ERASE_CMD && CHIP_CMD != SECT_CMD)
         else $error("command codes must differ");
   end

   op_state_t         state, nxt;
   logic [ADDR_W-1:0] last_addr;
   logic [7:0]        last_data;
   logic              erase_job, erase_job_n;
   logic [SECT_N-1:0] sel, sel_n;
   logic              op_start, prog_fire, erase_fire;
   logic              ld;
   logic [CW-1:0]     ldv;
   logic              tmr_done;
   logic              wr_pulse, go_prog, go_chip, go_sect;
   logic              armed, busy, failed;
   logic [SW-1:0]     wr_sec;
   logic [SECT_N-1:0] wr_hot;
   logic [7:0]        bank_rd [SECT_N];
   logic [7:0]        array_byte;

   assign armed  = (state == ST_READ);
   assign busy   = (state != ST_READ);
   assign failed = (state == ST_FAIL);
   assign wr_sec = addr[ADDR_W-1:OW];
   assign wr_hot = SECT_N'(1) << wr_sec;

   fos_cmd_seq #(
      .PROG_CMD (PROG_CMD),
      .ERASE_CMD(ERASE_CMD),
      .CHIP_CMD (CHIP_CMD),
      .SECT_CMD (SECT_CMD)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (ce_n),
      .we_n    (we_n),
      .wdata   (wdata),
      .armed   (armed),
      .wr_pulse(wr_pulse),
      .go_prog (go_prog),
      .go_chip (go_chip),
      .go_sect (go_sect)
   );

   fos_busy_timer #(.CW(CW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ld),
      .load_val(ldv),
      .done    (tmr_done)
   );

   always_comb begin
      nxt         = state;
      sel_n       = sel;
      erase_job_n = erase_job;
      op_start    = 1'b0;
      prog_fire   = 1'b0;
      erase_fire  = 1'b0;
      ld          = 1'b0;
      ldv         = '0;
      case (state)
         ST_READ: begin
            if (go_prog) begin
               op_start    = 1'b1;
               erase_job_n = 1'b0;
               ld          = 1'b1;
               if (sect_prot[wr_sec]) begin
                  nxt = ST_PPROT;
                  ldv = CW'(PPROT_CYC);
               end else begin
                  nxt = ST_PROG;
                  ldv = CW'(PROG_CYC);
               end
            end else if (go_chip) begin
               op_start    = 1'b1;
               erase_job_n = 1'b1;
               sel_n       = '1;
               ld          = 1'b1;
               if (&sect_prot) begin
                  nxt = ST_EPROT;
                  ldv = CW'(EPROT_CYC);
               end else begin
                  nxt = ST_ERASE;
                  ldv = CW'(ERASE_CYC);
               end
            end else if (go_sect) begin
               op_start    = 1'b1;
               erase_job_n = 1'b1;
               sel_n       = wr_hot;
               ld          = 1'b1;
               ldv         = CW'(WIN_CYC);
               nxt         = ST_EWIN;
            end
         end
         ST_PROG: begin
            if (pulse_limit) nxt = ST_FAIL;
            else if (tmr_done) begin
               prog_fire = 1'b1;
               nxt       = ST_READ;
            end
         end
         ST_PPROT: begin
            if (pulse_limit)   nxt = ST_FAIL;
            else if (tmr_done) nxt = ST_READ;
         end
         ST_EWIN: begin
            if (pulse_limit) nxt = ST_FAIL;
            else if (wr_pulse && wdata == SECT_CMD) begin
               sel_n = sel | wr_hot;
               ld    = 1'b1;
               ldv   = CW'(WIN_CYC);
            end else if (tmr_done) begin
               ld = 1'b1;
               if ((sel & ~sect_prot) == '0) begin
                  nxt = ST_EPROT;
                  ldv = CW'(EPROT_CYC);
               end else begin
                  nxt = ST_ERASE;
                  ldv = CW'(ERASE_CYC);
               end
            end
         end
         ST_ERASE: begin
            if (pulse_limit) nxt = ST_FAIL;
            else if (tmr_done) begin
               erase_fire = 1'b1;
               nxt        = ST_READ;
            end
         end
         ST_EPROT: begin
            if (pulse_limit)   nxt = ST_FAIL;
            else if (tmr_done) nxt = ST_READ;
         end
         ST_FAIL: begin
            if (wr_pulse && wdata == RST_CMD) nxt = ST_READ;
         end
         default: nxt = ST_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_READ;
         sel       <= '0;
         erase_job <= 1'b0;
         last_addr <= '0;
         last_data <= '0;
      end else begin
         state     <= nxt;
         sel       <= sel_n;
         erase_job <= erase_job_n;
         if (go_prog && armed) begin
            last_addr <= addr;
            last_data <= wdata;
         end
      end
   end

   for (genvar s = 0; s < SECT_N; s++) begin : g_sect
      fos_sector #(.WORDS(SECT_WORDS), .OFS_W(OW)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (prog_fire && (last_addr[ADDR_W-1:OW] == SW'(s))),
         .wr_ofs  (last_addr[OW-1:0]),
         .wr_data (last_data),
         .erase_en(erase_fire && sel[s] && !sect_prot[s]),
         .rd_ofs  (addr[OW-1:0]),
         .rd_data (bank_rd[s])
      );
   end

   assign array_byte = bank_rd[wr_sec];

   fos_read_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .busy      (busy),
      .op_start  (op_start),
      .erase_job (erase_job),
      .target_d7 (last_data[7]),
      .failed    (failed),
      .array_byte(array_byte),
      .rdata     (rdata)
   );

   a_r2_poll_inverted: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_PROG || state == ST_PPROT) && !ce_n && !oe_n)
         |-> (rdata[7] == ~last_data[7] && rdata[4:0] == 5'b0));

   a_r3_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_EWIN || state == ST_ERASE || state == ST_EPROT) && !ce_n && !oe_n)
         |-> (rdata[7] == 1'b0));

   a_r8_fail_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (failed && !ce_n && !oe_n) |-> rdata[5]);

   a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (failed && !(wr_pulse && wdata == RST_CMD)) |=> failed);

   a_r9_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EWIN && !pulse_limit && wr_pulse && wdata == SECT_CMD) |=> (state == ST_EWIN));

endmodule

// File: tb/flash_op_status_tb.sv
module flash_op_status_tb;

   localparam logic [7:0] PROG_CMD  = 8'hA0;
   localparam logic [7:0] ERASE_CMD = 8'h80;
   localparam logic [7:0] CHIP_CMD  = 8'h10;
   localparam logic [7:0] SECT_CMD  = 8'h30;
   localparam logic [7:0] RST_CMD   = 8'hF0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_n = 1'b1;
   logic       oe_n = 1'b1;
   logic       we_n = 1'b1;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [3:0] sect_prot = '0;
   logic       pulse_limit = 1'b0;
   logic [7:0] rdata;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;

   typedef struct {
      logic [7:0] exp;
      logic [7:0] mask;
      string      tag;
   } exp_t;

   exp_t       exp_q[$];
   logic [7:0] act_q[$];

   always #5 clk = ~clk;

   flash_op_status u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .oe_n       (oe_n),
      .we_n       (we_n),
      .addr       (addr),
      .wdata      (wdata),
      .sect_prot  (sect_prot),
      .pulse_limit(pulse_limit),
      .rdata      (rdata)
   );

   // Monitor: pops expected and observed items and compares them.
   always @(negedge clk) begin
      while (exp_q.size() > 0 && act_q.size() > 0) begin
         exp_t       e;
         logic [7:0] a;
         e = exp_q.pop_front();
         a = act_q.pop_front();
         n_checks++;
         if ((a & e.mask) !== (e.exp & e.mask)) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h (mask %02h)", e.tag, a, e.exp, e.mask);
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr  = a;
      wdata = d;
      ce_n  = 1'b0;
      we_n  = 1'b0;
      @(negedge clk);
      we_n  = 1'b1;
      @(negedge clk);
      ce_n  = 1'b1;
   endtask

   // kind 0: release both, 1: release oe only, 2: release ce only
   task automatic rd(input logic [3:0] a, input int kind, input logic [7:0] e,
                     input logic [7:0] m, input string tag);
      exp_q.push_back('{exp: e, mask: m, tag: tag});
      @(negedge clk);
      addr = a;
      ce_n = 1'b0;
      oe_n = 1'b0;
      @(negedge clk);
      act_q.push_back(rdata);
      if (kind != 2) oe_n = 1'b1;
      if (kind != 1) ce_n = 1'b1;
   endtask

   task automatic prog_seq(input logic [3:0] a, input logic [7:0] d);
      wr(4'h5, 8'hAA);
      wr(4'h2, 8'h55);
      wr(4'h5, PROG_CMD);
      wr(a, d);
   endtask

   task automatic erase_pre();
      wr(4'h5, 8'hAA);
      wr(4'h2, 8'h55);
      wr(4'h5, ERASE_CMD);
      wr(4'h5, 8'hAA);
      wr(4'h2, 8'h55);
   endtask

   task automatic strobe_limit();
      @(negedge clk);
      pulse_limit = 1'b1;
      @(negedge clk);
      pulse_limit = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: reset contents and idle output
      rd(4'h0, 0, 8'hFF, 8'hFF, "R1 reset array byte");
      exp_q.push_back('{exp: 8'h00, mask: 8'hFF, tag: "R1 idle output zero"});
      @(negedge clk);
      act_q.push_back(rdata);

      // R4 then R2/R5: program 3C at 1
      wr(4'h5, 8'hAA);
      wr(4'h2, 8'h55);
      wr(4'h5, PROG_CMD);
      rd(4'h1, 0, 8'hFF, 8'hFF, "R4 read before 4th pulse");
      wr(4'h1, 8'h3C);
      rd(4'h1, 0, 8'h80, 8'hFF, "R2 program status first read");
      rd(4'h1, 1, 8'hC0, 8'hFF, "R5 toggle after read");
      rd(4'h1, 2, 8'h80, 8'hFF, "R5 toggle after oe-ended read");
      rd(4'h1, 0, 8'hC0, 8'hFF, "R5 toggle after ce-ended read");
      repeat (50) @(negedge clk);
      rd(4'h1, 0, 8'h3C, 8'hFF, "R2 programmed byte");
      rd(4'h1, 0, 8'h3C, 8'hFF, "R5 toggling stopped");

      // R2: data with bit7 set
      prog_seq(4'h2, 8'hC3);
      rd(4'h2, 0, 8'h00, 8'hFF, "R2 status for bit7 set");
      repeat (50) @(negedge clk);
      rd(4'h2, 0, 8'hC3, 8'hFF, "R2 programmed byte C3");

      // R10: broken sequences
      wr(4'h5, 8'hAA);
      wr(4'h2, 8'h55);
      wr(4'h5, 8'h55);
      rd(4'h5, 0, 8'hFF, 8'hFF, "R10 bad 3rd code no status");
      prog_seq(4'h6, 8'h11);
      rd(4'h6, 0, 8'h80, 8'hFF, "R10 fresh sequence after break");
      repeat (50) @(negedge clk);
      rd(4'h6, 0, 8'h11, 8'hFF, "R10 byte after fresh sequence");
      erase_pre();
      wr(4'h0, 8'h77);
      rd(4'h1, 0, 8'h3C, 8'hFF, "R10 bad 6th code no status");

      // Prepare sector 2 data
      prog_seq(4'h8, 8'h5A);
      repeat (50) @(negedge clk);
      rd(4'h8, 0, 8'h5A, 8'hFF, "R2 programmed byte 5A");

      // R4/R9/R3: sector erase with window extension
      erase_pre();
      rd(4'h1, 0, 8'h3C, 8'hFF, "R4 read before 6th pulse");
      wr(4'h0, SECT_CMD);
      rd(4'h0, 0, 8'h00, 8'hFF, "R9 status in erase window");
      repeat (26) @(negedge clk);
      wr(4'h4, SECT_CMD);
      repeat (325) @(negedge clk);
      rd(4'h1, 0, 8'h00, 8'hBF, "R9 window restarted, still busy");
      repeat (40) @(negedge clk);
      rd(4'h1, 0, 8'hFF, 8'hFF, "R3 sector 0 erased");
      rd(4'h6, 0, 8'hFF, 8'hFF, "R9 added sector 1 erased");
      rd(4'h2, 0, 8'hFF, 8'hFF, "R3 sector 0 second byte");
      rd(4'h8, 0, 8'h5A, 8'hFF, "R3 unselected sector kept");

      // R6: program into protected sector 2
      sect_prot = 4'b0100;
      prog_seq(4'h9, 8'h00);
      rd(4'h9, 0, 8'h80, 8'hBF, "R6 protected program status");
      repeat (150) @(negedge clk);
      rd(4'h9, 0, 8'h80, 8'hBF, "R6 protected program still busy");
      repeat (60) @(negedge clk);
      rd(4'h9, 0, 8'hFF, 8'hFF, "R6 protected byte unchanged");

      // R7: chip erase skips protected sector
      prog_seq(4'hC, 8'h12);
      repeat (50) @(negedge clk);
      erase_pre();
      wr(4'h0, CHIP_CMD);
      rd(4'h0, 0, 8'h00, 8'hBF, "R7 chip erase status");
      repeat (320) @(negedge clk);
      rd(4'hC, 0, 8'hFF, 8'hFF, "R7 chip erase cleared sector 3");
      rd(4'h8, 0, 8'h5A, 8'hFF, "R7 protected sector kept");

      // R7: all selected sectors protected
      erase_pre();
      wr(4'h8, SECT_CMD);
      rd(4'h8, 0, 8'h00, 8'hBF, "R7 all-protected erase status");
      repeat (5000) @(negedge clk);
      rd(4'h8, 0, 8'h00, 8'hBF, "R7 all-protected still busy");
      repeat (5100) @(negedge clk);
      rd(4'h8, 0, 8'h5A, 8'hFF, "R7 all-protected no change");

      // R8: failure during program
      sect_prot = 4'b0000;
      prog_seq(4'hD, 8'h7E);
      strobe_limit();
      rd(4'hD, 0, 8'hA0, 8'hBF, "R8 program failure flag");
      repeat (60) @(negedge clk);
      rd(4'hD, 0, 8'hA0, 8'hBF, "R8 failure persists");
      wr(4'h0, RST_CMD);
      rd(4'hD, 0, 8'hFF, 8'hFF, "R8 failed program left byte");

      // R8: failure during erase
      prog_seq(4'h4, 8'h66);
      repeat (50) @(negedge clk);
      erase_pre();
      wr(4'h4, SECT_CMD);
      strobe_limit();
      rd(4'h4, 0, 8'h20, 8'hBF, "R8 erase failure flag");
      repeat (400) @(negedge clk);
      rd(4'h4, 0, 8'h20, 8'hBF, "R8 erase failure persists");
      wr(4'h0, RST_CMD);
      rd(4'h4, 0, 8'h66, 8'hFF, "R8 failed erase left data");

      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule